// File: doc/BRIEF.md
# 16-bit Address Arithmetic Unit

This purely combinational unit produces the 16-bit values that an 8-bit processor core needs for pointer and stack work. It covers several jobs:

- register-pair increment and decrement;
- the 16-bit add into the HL pair;
- stack-pointer plus signed byte, with the sum meant either for the stack pointer or for HL;
- high-page addresses at 0xFF00 plus a byte;
- HL post-increment and post-decrement pointer accesses;
- relative branch targets;
- restart vector addresses.

The surrounding sequencer selects an operation, presents two 16-bit operands, an 8-bit immediate and the current flags. In the same cycle it takes back a 16-bit result, a bus address and the updated flags.

Flags are packed as a 4-bit vector: bit 3 is Z, bit 2 is N, bit 1 is H and bit 0 is C. Operand A carries the pointer, stack pointer or program counter. Operand B carries the second register pair, and its low byte doubles as register C for the high-page form.

The operation codes are as follows:

- 0: increment
- 1: decrement
- 2: add into HL
- 3: stack offset to SP
- 4: stack offset to HL
- 5: high page from the immediate
- 6: high page from C
- 7: post-increment
- 8: post-decrement
- 9: relative branch
- 10: restart

Top module: `addr_unit16`

## Requirements
- R1: For codes 0 and 1, result is operand A plus one or minus one, and flags_out equals flags_in.
- R2: For code 2, result is A+B, N is cleared, Z is kept, H is the carry out of bit 11 and C is the carry out of bit 15.
- R3: For codes 3 and 4, result is A plus the sign-extended immediate (-128..127), identical for both codes.
- R4: For codes 3 and 4, Z and N are cleared; H is the carry out of bit 3 and C the carry out of bit 7 of the unsigned add of the immediate to the low byte of A.
- R5: Code 5 gives 0xFF00 plus the immediate and code 6 gives 0xFF00 plus B[7:0]; flags are unchanged.
- R6: Codes 7 and 8 put the old A on addr_out and A+1 or A-1 on result; flags are unchanged.
- R7: Code 9 gives A plus the sign-extended immediate, with flags unchanged.
- R8: Code 10 gives the immediate's low 3 bits times 8 (0x00..0x38); the upper immediate bits are ignored and flags are unchanged.
- R9: All 16-bit sums wrap modulo 65536 with no other indication.
- R10: Codes 11 to 15 pass A to result and leave the flags unchanged.
- R11: For every code other than 7 and 8, addr_out equals result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 16 | Pointer, SP or PC operand |
| opnd_b | input | 16 | Second pair; low byte is register C |
| imm8 | input | 8 | Immediate byte |
| flags_in | input | 4 | Incoming Z,N,H,C |
| result | output | 16 | Value to write back |
| addr_out | output | 16 | Address for the bus |
| flags_out | output | 4 | Updated Z,N,H,C |

## Verification
Assertions watch the structural rules on every input change:

- flag preservation for the non-flag operations;
- the 0xFF upper byte of high-page addresses;
- the aligned shape of restart vectors;
- the old pointer on the address of post-modify accesses;
- cleared N and kept Z for the HL add.

Only the bench's vectors show that the arithmetic values are right. These include the bit-3/bit-7 half and full carries of the signed stack offset, the bit-11/bit-15 carries of the HL add, negative offsets and wrap-around at 0x0000 and 0xFFFF.

// File: rtl/adu_pkg.sv
// Shared widths, flag bit positions and operation codes for the address unit.
package adu_pkg;
    localparam int ADU_W    = 16;
    localparam int ADU_BW   = 8;
    localparam int ADU_FW   = 4;
    localparam int FLG_Z    = 3;
    localparam int FLG_N    = 2;
    localparam int FLG_H    = 1;
    localparam int FLG_C    = 0;

    typedef enum logic [3:0] {
        OP_INC16   = 4'd0,
        OP_DEC16   = 4'd1,
        OP_ADD_HL  = 4'd2,
        OP_SPOFS_S = 4'd3,
        OP_SPOFS_H = 4'd4,
        OP_PAGE_IM = 4'd5,
        OP_PAGE_C  = 4'd6,
        OP_PTR_INC = 4'd7,
        OP_PTR_DEC = 4'd8,
        OP_REL_BR  = 4'd9,
        OP_RESTART = 4'd10
    } adu_op_e;
endpackage

// File: rtl/adu_incdec.sv
// Step unit: adds or subtracts one from a W-bit value, wrapping.
// Assumes nothing about the operand; no flags are produced here.
module adu_incdec #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         down_i,
    output logic [W-1:0] step_o
);
    localparam logic [W-1:0] ONE = W'(1);

    // Select the increment or decrement of the operand.
    always_comb begin
        if (down_i) step_o = val_i - ONE;
        else        step_o = val_i + ONE;
    end
endmodule

// File: rtl/adu_pair_add.sv
// Pair adder: W-bit unsigned add exposing the carry out of bit MID-1
// (half carry) and of the top bit. Assumes MID < W.
module adu_pair_add #(
    parameter int W   = 16,
    parameter int MID = 12
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o,
    output logic         cmid_o,
    output logic         ctop_o
);
    logic [W:0]   full_s;
    logic [MID:0] part_s;

    // Full-width and lower-slice sums; the slice yields the half carry.
    always_comb begin
        full_s = {1'b0, x_i} + {1'b0, y_i};
        part_s = {1'b0, x_i[MID-1:0]} + {1'b0, y_i[MID-1:0]};
        sum_o  = full_s[W-1:0];
        ctop_o = full_s[W];
        cmid_o = part_s[MID];
    end
endmodule

// File: rtl/adu_ofs_add.sv
// Signed-byte offset adder: base plus sign-extended BW-bit offset, with the
// unsigned carries of the offset byte into the base's low byte at nibble and
// byte boundaries. Assumes BW is even and BW < W.
module adu_ofs_add #(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  logic [W-1:0]  base_i,
    input  logic [BW-1:0] ofs_i,
    output logic [W-1:0]  sum_o,
    output logic          cnib_o,
    output logic          cbyte_o
);
    localparam int NIB = BW / 2;

    logic [W-1:0] ext_s;
    logic [BW:0]  lowb_s;
    logic [NIB:0] nib_s;

    // Sign-extend the offset and form the wrapped sum and low-byte carries.
    always_comb begin
        ext_s   = {{(W-BW){ofs_i[BW-1]}}, ofs_i};
        sum_o   = base_i + ext_s;
        lowb_s  = {1'b0, base_i[BW-1:0]} + {1'b0, ofs_i};
        nib_s   = {1'b0, base_i[NIB-1:0]} + {1'b0, ofs_i[NIB-1:0]};
        cbyte_o = lowb_s[BW];
        cnib_o  = nib_s[NIB];
    end
endmodule

// File: rtl/adu_vec_gen.sv
// Fixed-address former: high-page address (all-ones upper part plus a byte
// chosen from immediate or register) and restart vector (index << SHIFT).
// Assumes IDXW + SHIFT <= W.
module adu_vec_gen #(
    parameter int W     = 16,
    parameter int BW    = 8,
    parameter int IDXW  = 3,
    parameter int SHIFT = 3
) (
    input  logic            use_reg_i,
    input  logic [BW-1:0]   imm_i,
    input  logic [BW-1:0]   reg_i,
    input  logic [IDXW-1:0] idx_i,
    output logic [W-1:0]    page_o,
    output logic [W-1:0]    rst_o
);
    localparam int PAD = W - IDXW - SHIFT;

    // High-page address from the selected byte.
    always_comb begin
        page_o = {{(W-BW){1'b1}}, (use_reg_i ? reg_i : imm_i)};
    end

    generate
        if (PAD > 0) begin : g_pad
            // Restart vector with zero padding above the index.
            always_comb rst_o = {{PAD{1'b0}}, idx_i, {SHIFT{1'b0}}};
        end else begin : g_nopad
            // Restart vector filling the full width.
            always_comb rst_o = {idx_i, {SHIFT{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/addr_unit16.sv
// 16-bit address arithmetic unit (combinational). Selects among step,
// pair-add, signed-offset and fixed-address results and forms the flags.
// Assumes the sequencer samples outputs once inputs are settled; no state.
module addr_unit16
    import adu_pkg::*;
(
    input  logic [3:0]  op_sel,
    input  logic [15:0] opnd_a,
    input  logic [15:0] opnd_b,
    input  logic [7:0]  imm8,
    input  logic [3:0]  flags_in,
    output logic [15:0] result,
    output logic [15:0] addr_out,
    output logic [3:0]  flags_out
);
    localparam int W       = ADU_W;
    localparam int BW      = ADU_BW;
    localparam int HALF_HL = 12;
    localparam int VIDX    = 3;
    localparam int VSHIFT  = 3;

    adu_op_e      op_s;
    logic         step_down;
    logic [W-1:0] step_y, pair_y, ofs_y, page_y, rst_y;
    logic         pair_cmid, pair_ctop, ofs_cnib, ofs_cbyte;

    // Decode the operation code and the step direction.
    always_comb begin
        op_s      = adu_op_e'(op_sel);
        step_down = (op_s == OP_DEC16) || (op_s == OP_PTR_DEC);
    end

    adu_incdec #(.W(W)) step_i (
        .val_i (opnd_a),
        .down_i(step_down),
        .step_o(step_y)
    );

    adu_pair_add #(.W(W), .MID(HALF_HL)) pair_i (
        .x_i   (opnd_a),
        .y_i   (opnd_b),
        .sum_o (pair_y),
        .cmid_o(pair_cmid),
        .ctop_o(pair_ctop)
    );

    adu_ofs_add #(.W(W), .BW(BW)) ofs_i (
        .base_i (opnd_a),
        .ofs_i  (imm8),
        .sum_o  (ofs_y),
        .cnib_o (ofs_cnib),
        .cbyte_o(ofs_cbyte)
    );

    adu_vec_gen #(.W(W), .BW(BW), .IDXW(VIDX), .SHIFT(VSHIFT)) vec_i (
        .use_reg_i(op_s == OP_PAGE_C),
        .imm_i    (imm8),
        .reg_i    (opnd_b[BW-1:0]),
        .idx_i    (imm8[VIDX-1:0]),
        .page_o   (page_y),
        .rst_o    (rst_y)
    );

    // Result, bus address and flag selection per operation.
    always_comb begin
        result    = opnd_a;
        addr_out  = opnd_a;
        flags_out = flags_in;
        unique case (op_s)
            OP_INC16, OP_DEC16: begin
                result   = step_y;
                addr_out = step_y;
            end
            OP_PTR_INC, OP_PTR_DEC: begin
                result   = step_y;
                addr_out = opnd_a;
            end
            OP_ADD_HL: begin
                result           = pair_y;
                addr_out         = pair_y;
                flags_out[FLG_N] = 1'b0;
                flags_out[FLG_H] = pair_cmid;
                flags_out[FLG_C] = pair_ctop;
            end
            OP_SPOFS_S, OP_SPOFS_H: begin
                result    = ofs_y;
                addr_out  = ofs_y;
                flags_out = '0;
                flags_out[FLG_H] = ofs_cnib;
                flags_out[FLG_C] = ofs_cbyte;
            end
            OP_REL_BR: begin
                result   = ofs_y;
                addr_out = ofs_y;
            end
            OP_PAGE_IM, OP_PAGE_C: begin
                result   = page_y;
                addr_out = page_y;
            end
            OP_RESTART: begin
                result   = rst_y;
                addr_out = rst_y;
            end
            default: begin
                result   = opnd_a;
                addr_out = opnd_a;
            end
        endcase
    end

    // Structural checks on the settled outputs.
    always_comb begin
        // R1
        flags_keep_chk: assert (!(op_sel inside {4'd0, 4'd1, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10})
                                || flags_out == flags_in);
        // R2
        hl_flag_chk: assert (op_sel != 4'd2
                             || (flags_out[FLG_N] == 1'b0 && flags_out[FLG_Z] == flags_in[FLG_Z]));
        // R4
        spofs_zn_chk: assert (!(op_sel inside {4'd3, 4'd4})
                              || (flags_out[FLG_Z] == 1'b0 && flags_out[FLG_N] == 1'b0));
        // R5
        page_top_chk: assert (!(op_sel inside {4'd5, 4'd6}) || addr_out[15:8] == 8'hFF);
        // R6
        ptr_addr_chk: assert (!(op_sel inside {4'd7, 4'd8}) || addr_out == opnd_a);
        // R8
        rst_shape_chk: assert (op_sel != 4'd10
                               || (result[15:6] == 10'd0 && result[2:0] == 3'd0));
        // R11
        addr_eq_chk: assert ((op_sel inside {4'd7, 4'd8}) || addr_out == result);
    end
endmodule

// File: tb/addr_unit16_tb.sv
// Vector-table bench for addr_unit16 followed by directed sweeps.
module addr_unit16_tb_top;
    logic        clk = 1'b0;
    logic [3:0]  op_sel;
    logic [15:0] opnd_a, opnd_b;
    logic [7:0]  imm8;
    logic [3:0]  flags_in;
    logic [15:0] result, addr_out;
    logic [3:0]  flags_out;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    addr_unit16 dut_i (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm8(imm8),
        .flags_in(flags_in), .result(result), .addr_out(addr_out),
        .flags_out(flags_out)
    );

    // Entry: {req, op, a, b, imm, fin, exp_result, exp_addr, exp_flags}
    localparam int NV = 20;
    localparam logic [87:0] VEC [NV] = '{
        {4'd1,  4'h0, 16'h1234, 16'h0000, 8'h00, 4'hF, 16'h1235, 16'h1235, 4'hF}, // R1
        {4'd9,  4'h0, 16'hFFFF, 16'h0000, 8'h00, 4'h0, 16'h0000, 16'h0000, 4'h0}, // R9
        {4'd9,  4'h1, 16'h0000, 16'h0000, 8'h00, 4'hA, 16'hFFFF, 16'hFFFF, 4'hA}, // R9
        {4'd2,  4'h2, 16'h0FFF, 16'h0001, 8'h00, 4'h8, 16'h1000, 16'h1000, 4'hA}, // R2
        {4'd2,  4'h2, 16'h8000, 16'h8000, 8'h00, 4'h4, 16'h0000, 16'h0000, 4'h1}, // R2
        {4'd2,  4'h2, 16'hFFFF, 16'h0001, 8'h00, 4'h0, 16'h0000, 16'h0000, 4'h3}, // R2
        {4'd4,  4'h3, 16'hFFF8, 16'h0000, 8'h08, 4'hF, 16'h0000, 16'h0000, 4'h3}, // R4
        {4'd3,  4'h4, 16'h0005, 16'h0000, 8'hFE, 4'hC, 16'h0003, 16'h0003, 4'h3}, // R3
        {4'd3,  4'h3, 16'h1000, 16'h0000, 8'h80, 4'hF, 16'h0F80, 16'h0F80, 4'h0}, // R3
        {4'd4,  4'h4, 16'h0001, 16'h0000, 8'h7F, 4'h0, 16'h0080, 16'h0080, 4'h2}, // R4
        {4'd5,  4'h5, 16'h1234, 16'h0000, 8'h44, 4'h5, 16'hFF44, 16'hFF44, 4'h5}, // R5
        {4'd5,  4'h6, 16'h0000, 16'hAB0F, 8'h99, 4'h9, 16'hFF0F, 16'hFF0F, 4'h9}, // R5
        {4'd6,  4'h7, 16'hC000, 16'h0000, 8'h00, 4'h9, 16'hC001, 16'hC000, 4'h9}, // R6
        {4'd6,  4'h8, 16'h0000, 16'h0000, 8'h00, 4'h2, 16'hFFFF, 16'h0000, 4'h2}, // R6
        {4'd7,  4'h9, 16'h0150, 16'h0000, 8'hFB, 4'h6, 16'h014B, 16'h014B, 4'h6}, // R7
        {4'd7,  4'h9, 16'hFFF0, 16'h0000, 8'h20, 4'h1, 16'h0010, 16'h0010, 4'h1}, // R7
        {4'd8,  4'hA, 16'h1111, 16'h0000, 8'hFB, 4'hE, 16'h0018, 16'h0018, 4'hE}, // R8
        {4'd10, 4'hF, 16'hBEEF, 16'h1234, 8'h55, 4'h7, 16'hBEEF, 16'hBEEF, 4'h7}, // R10
        {4'd10, 4'hB, 16'h0042, 16'hFFFF, 8'hFF, 4'hB, 16'h0042, 16'h0042, 4'hB}, // R10
        {4'd11, 4'h2, 16'h1234, 16'h1111, 8'h00, 4'h0, 16'h2345, 16'h2345, 4'h0}  // R11
    };

    task automatic chk16(input int req, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [7:0] im, input logic [3:0] fi);
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; imm8 = im; flags_in = fi;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        op_sel = 4'hF; opnd_a = '0; opnd_b = '0; imm8 = '0; flags_in = '0;
        @(negedge clk);
        // Idle state: pass-through code with zero operands (R10).
        chk16(10, "idle result", result, 16'h0000);
        chk16(10, "idle flags", {12'd0, flags_out}, 16'h0000);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            logic [87:0] v;
            v = VEC[i];
            apply(v[83:80], v[79:64], v[63:48], v[47:40], v[39:36]);
            chk16(int'(v[87:84]), "result", result, v[35:20]);
            chk16(11, "addr", addr_out, v[19:4]);
            chk16(int'(v[87:84]), "flags", {12'd0, flags_out}, {12'd0, v[3:0]});
        end

        // R8: every restart index, upper immediate bits set.
        for (int k = 0; k < 8; k++) begin
            apply(4'hA, 16'hABCD, 16'h0, 8'hF8 | 8'(k), 4'h5);
            chk16(8, "restart", result, 16'(k * 8));
        end

        // R1: increment/decrement sweep with flags preserved.
        for (int k = 0; k < 16; k++) begin
            logic [15:0] a;
            a = 16'(k * 4099 + 7);
            apply(4'(k & 1), a, 16'h0, 8'h0, 4'(k));
            chk16(1, "incdec", result, (k & 1) ? a - 16'd1 : a + 16'd1);
            chk16(1, "incdec flags", {12'd0, flags_out}, 16'(k));
        end

        // R3: both stack offset codes give the same sum for a negative offset.
        apply(4'h3, 16'h0100, 16'h0, 8'hFF, 4'h0);
        chk16(3, "spofs to SP", result, 16'h00FF);
        apply(4'h4, 16'h0100, 16'h0, 8'hFF, 4'h0);
        chk16(3, "spofs to HL", result, 16'h00FF);
        chk16(4, "spofs flags", {12'd0, flags_out}, 16'h0000);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule